// File: doc/BRIEF.md
# Paged-Write Byte Memory Controller with Completion Status

This block models a byte-wide nonvolatile memory with an 8K x 8 array, seen from a host through enable-style strobes. A host write captures address and data inside the block at the moment the write strobe becomes active. Captured bytes collect in a 32-byte page buffer for a single page. A load-window timer starts again on every accepted write. When no further write arrives before it runs out, a self-timed programming cycle copies the collected bytes into the array and then empties the buffer.

The host has three ways to tell when programming has finished. It can watch the ready output. It can poll the data: while busy, bit 7 reads inverted from the last byte written. It can watch a toggle bit: bit 6 flips on each read while busy. A power-good input, active low, resets the control state and blocks every write while it is low. The array behaves as plain RAM, and the programming time is a parameter counted in clock cycles. The data bus is split into an input, an output and an output-drive enable, so a pad ring can build the bidirectional pin from them.

Top module: `pgw_eeprom`

## Requirements
- R1: While `pwr_ok_n` is low, `rdy` is 1 and `dq_oe` is 0. Write strobes issued in that state change no array byte and start no programming.
- R2: A read is active while `cs_n`=0, `rd_n`=0 and `wr_n`=1. Then `dq_oe`=1, and when not busy `dq_out` returns the array byte at `addr`.
- R3: A write is taken when `cs_n` and `wr_n` become jointly low. `addr` and `dq_in` are captured in that clock cycle, so later changes to them have no effect.
- R4: `addr[4:0]` selects the byte within a page and `addr[12:5]` selects the page. One programming cycle commits every byte loaded into the page, from 1 to 32 bytes. Bytes of that page that were not loaded keep their earlier contents.
- R5: Every accepted write restarts the load window. Programming begins (`rdy` falls) exactly LOAD_CYC clock cycles after the last accepted write, and `rdy` stays 1 while loading.
- R6: Once a page is open, writes whose `addr[12:5]` differ from the first byte's page are ignored.
- R7: `rdy` is 0 for exactly PROG_CYC cycles of programming, then returns to 1.
- R8: Writes that arrive while `rdy` is 0 are ignored and start no new load window.
- R9: While busy, a read returns bit 7 as the complement of bit 7 of the last accepted byte. After completion, reads return true data.
- R10: While busy, read bit 6 is 0 on the first read after programming starts and inverts after every read. Bits 5:0 read 0. After completion, repeated reads return identical data.
- R11: The byte used for data polling is the last accepted write, not a later ignored one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all strobes are sampled on its rising edge |
| pwr_ok_n | input | 1 | Active-low power-good / reset; blocks writes while low |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write enable |
| addr | input | 13 | Byte address: page in [12:5], byte in page in [4:0] |
| dq_in | input | 8 | Write data from the host |
| dq_out | output | 8 | Read data or completion status |
| dq_oe | output | 1 | High while the block drives the data bus |
| rdy | output | 1 | 1 when idle or loading, 0 while programming |

## Verification
The assertions assume that the host never asserts `rd_n` and `wr_n` together while selected. They also assume that strobes are held for at least one clock edge, so every write and every read produces exactly one detected edge, and that LOAD_CYC is at least 2. The bench's write and read tasks each hold a strobe for exactly one clock period and release it for at least one, and they change `addr` and `dq_in` only at falling clock edges. Writes issued during reset or while busy use the same tasks, so every scenario stays within those assumptions.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;

  // Status byte seen by the host while programming runs.
  function automatic logic [7:0] poll_status(input logic last_b7, input logic tog);
    return {~last_b7, tog, 6'b000000};
  endfunction

  // Join page and in-page offset into a full byte address.
  function automatic logic [12:0] join_addr(input logic [7:0] page, input logic [4:0] off);
    return {page, off};
  endfunction

endpackage

// File: rtl/pgw_strobe.sv
module pgw_strobe (
  input  logic clk,
  input  logic pwr_ok_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_strobe,
  output logic rd_active,
  output logic rd_end
);
  logic wr_act, wr_act_q, rd_act_q;

  assign wr_act    = pwr_ok_n & ~cs_n & ~wr_n;
  assign rd_active = pwr_ok_n & ~cs_n & ~rd_n & wr_n;

  always_ff @(posedge clk) begin
    if (!pwr_ok_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_active;
    end
  end

  assign wr_strobe = wr_act & ~wr_act_q;
  assign rd_end    = ~rd_active & rd_act_q;
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int LOAD_CYC = 40,
  parameter int PROG_CYC = 200,
  parameter int PAGE     = 32
) (
  input  logic                      clk,
  input  logic                      pwr_ok_n,
  input  logic                      wr_strobe,
  input  logic                      same_page,
  output phase_t                    phase,
  output logic                      wr_accept,
  output logic                      prog_start,
  output logic                      prog_done,
  output logic                      commit_en,
  output logic [$clog2(PAGE)-1:0]   commit_idx
);
  localparam int MAXC  = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int OFF_W = $clog2(PAGE);

  logic [CNT_W-1:0] cnt;

  assign wr_accept  = wr_strobe &
                      ((phase == PH_IDLE) | ((phase == PH_LOAD) & same_page));
  assign prog_start = (phase == PH_LOAD) & ~wr_accept & (cnt == '0);
  assign prog_done  = (phase == PH_PROG) & (cnt == CNT_W'(PROG_CYC - 1));
  assign commit_en  = (phase == PH_PROG) & (cnt < CNT_W'(PAGE));
  assign commit_idx = cnt[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!pwr_ok_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (wr_accept) begin
          phase <= PH_LOAD;
          cnt   <= CNT_W'(LOAD_CYC - 1);
        end
        PH_LOAD: begin
          if (wr_accept) begin
            cnt <= CNT_W'(LOAD_CYC - 1);
          end else if (prog_start) begin
            phase <= PH_PROG;
            cnt   <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_PROG: begin
          if (prog_done) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE   = 32,
  parameter int PG_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     pwr_ok_n,
  input  logic                     wr_accept,
  input  logic                     clear,
  input  logic [PG_W-1:0]          pg_in,
  input  logic [$clog2(PAGE)-1:0]  off_in,
  input  logic [DATA_W-1:0]        din,
  input  logic [$clog2(PAGE)-1:0]  rd_idx,
  input  logic                     open,
  output logic                     same_page,
  output logic [PG_W-1:0]          tag,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        last_data
);
  logic [DATA_W-1:0] bytes_q [PAGE];
  logic [PAGE-1:0]   mask_q;

  assign same_page = (pg_in == tag);
  assign rd_data   = bytes_q[rd_idx];
  assign rd_valid  = mask_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!pwr_ok_n) begin
      mask_q    <= '0;
      tag       <= '0;
      last_data <= '0;
    end else if (clear) begin
      mask_q <= '0;
    end else if (wr_accept) begin
      mask_q[off_in] <= 1'b1;
      last_data      <= din;
      if (!open) tag <= pg_in;
    end
  end

  generate
    for (genvar i = 0; i < PAGE; i++) begin : g_byte
      always_ff @(posedge clk) begin
        if (wr_accept && off_in == i) bytes_q[i] <= din;
      end
    end
  endgenerate
endmodule

// File: rtl/pgw_eeprom.sv
module pgw_eeprom
  import pgw_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int PAGE     = 32,
  parameter int LOAD_CYC = 40,
  parameter int PROG_CYC = 200
) (
  input  logic              clk,
  input  logic              pwr_ok_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              rdy
);
  localparam int OFF_W = $clog2(PAGE);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int DEPTH = 1 << ADDR_W;

  phase_t           phase;
  logic             wr_strobe, rd_active, rd_end;
  logic             wr_accept, prog_start, prog_done, commit_en;
  logic [OFF_W-1:0] commit_idx;
  logic             same_page, buf_valid;
  logic [PG_W-1:0]  tag;
  logic [7:0]       buf_data, last_data;
  logic             tog_q;
  logic             busy;
  logic [7:0]       mem [DEPTH];

  pgw_strobe u_strobe (
    .clk(clk), .pwr_ok_n(pwr_ok_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_strobe(wr_strobe), .rd_active(rd_active), .rd_end(rd_end)
  );

  pgw_seq #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .PAGE(PAGE)) u_seq (
    .clk(clk), .pwr_ok_n(pwr_ok_n), .wr_strobe(wr_strobe), .same_page(same_page),
    .phase(phase), .wr_accept(wr_accept), .prog_start(prog_start),
    .prog_done(prog_done), .commit_en(commit_en), .commit_idx(commit_idx)
  );

  pgw_page_buf #(.PAGE(PAGE), .PG_W(PG_W), .DATA_W(8)) u_buf (
    .clk(clk), .pwr_ok_n(pwr_ok_n), .wr_accept(wr_accept), .clear(prog_done),
    .pg_in(addr[ADDR_W-1:OFF_W]), .off_in(addr[OFF_W-1:0]), .din(dq_in),
    .rd_idx(commit_idx), .open(phase == PH_LOAD), .same_page(same_page),
    .tag(tag), .rd_data(buf_data), .rd_valid(buf_valid), .last_data(last_data)
  );

  assign busy = (phase == PH_PROG);
  assign rdy  = ~busy;

  // Array commit: one buffered byte per cycle at the start of programming.
  always_ff @(posedge clk) begin
    if (commit_en && buf_valid) mem[{tag, commit_idx}] <= buf_data;
  end

  // Toggle bit: cleared when programming starts, flips at the end of each busy read.
  always_ff @(posedge clk) begin
    if (!pwr_ok_n)             tog_q <= 1'b0;
    else if (prog_start)       tog_q <= 1'b0;
    else if (rd_end && busy)   tog_q <= ~tog_q;
  end

  assign dq_oe  = rd_active;
  assign dq_out = !rd_active ? 8'h00 :
                  busy       ? poll_status(last_data[7], tog_q) :
                               mem[addr];
endmodule

// File: rtl/pgw_eeprom_chk.sv
module pgw_eeprom_chk #(
  parameter int PROG_CYC = 200
) (
  input logic       clk,
  input logic       pwr_ok_n,
  input logic       rdy,
  input logic       wr_strobe,
  input logic       wr_accept,
  input logic       rd_end,
  input logic       tog_q,
  input logic       dq_oe,
  input logic [7:0] dq_out
);
  localparam int BC_W = $clog2(PROG_CYC + 2);
  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!pwr_ok_n)  busy_cnt <= '0;
    else if (!rdy)  busy_cnt <= busy_cnt + 1'b1;
    else            busy_cnt <= '0;
  end

  // R1
  rst_rdy_chk: assert property (@(posedge clk) !pwr_ok_n |=> (rdy && !dq_oe));

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!pwr_ok_n)
    (wr_strobe && !rdy) |-> !wr_accept);

  // R5
  load_restart_chk: assert property (@(posedge clk) disable iff (!pwr_ok_n)
    wr_accept |=> rdy);

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!pwr_ok_n)
    busy_cnt <= BC_W'(PROG_CYC));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!pwr_ok_n)
    $rose(rdy) |-> busy_cnt == BC_W'(PROG_CYC));

  // R10
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!pwr_ok_n)
    (rd_end && !rdy) |=> tog_q != $past(tog_q));

  // R10
  status_low_bits_chk: assert property (@(posedge clk) disable iff (!pwr_ok_n)
    (dq_oe && !rdy) |-> dq_out[5:0] == 6'd0);
endmodule

bind pgw_eeprom pgw_eeprom_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .pwr_ok_n(pwr_ok_n), .rdy(rdy), .wr_strobe(wr_strobe),
  .wr_accept(wr_accept), .rd_end(rd_end), .tog_q(tog_q),
  .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/tb_pgw_eeprom.sv
module tb_pgw_eeprom;
  localparam int LOAD_CYC = 40;
  localparam int PROG_CYC = 200;

  logic        clk = 1'b0;
  logic        pwr_ok_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe, rdy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pgw_eeprom #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) dut (
    .clk(clk), .pwr_ok_n(pwr_ok_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .rdy(rdy)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [12:0] at(input int pg, input int off);
    return {8'(pg), 5'(off)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dq_in = d; cs_n = 0; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1; addr = 13'h1FFF; dq_in = 8'hA5;
  endtask

  task automatic do_read(input logic [12:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; cs_n = 0; rd_n = 0;
    @(negedge clk); d = dq_out; oe = dq_oe; rd_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 4 * PROG_CYC && !rdy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rdy == 1'b1, "R1 rdy in reset", rdy, 1);
    check(dq_oe == 1'b0, "R1 no drive in reset", dq_oe, 0);
    @(negedge clk); pwr_ok_n = 1;
  endtask

  task automatic t_page();
    logic [7:0] d, d2; logic oe;
    for (int i = 0; i < 32; i++) do_write(at(2, i), pat(i));
    check(rdy == 1'b1, "R5 rdy while loading", rdy, 1);
    repeat (LOAD_CYC - 1) @(negedge clk);
    check(rdy == 1'b1, "R5 window not yet over", rdy, 1);
    @(negedge clk);
    check(rdy == 1'b0, "R5 R7 programming started", rdy, 0);
    do_read(at(2, 0), d, oe);
    check(oe == 1'b1, "R2 drive during read", oe, 1);
    check(d[7] == ~pat(31)[7], "R9 poll bit7", d[7], ~pat(31)[7]);
    check(d[6] == 1'b0, "R10 toggle first", d[6], 0);
    check(d[5:0] == 6'd0, "R10 low bits", d[5:0], 0);
    do_read(at(2, 0), d, oe);
    check(d[6] == 1'b1, "R10 toggle second", d[6], 1);
    do_read(at(2, 0), d, oe);
    check(d[6] == 1'b0, "R10 toggle third", d[6], 0);
    wait_ready();
    check(rdy == 1'b1, "R7 ready returns", rdy, 1);
    for (int i = 0; i < 32; i++) begin
      do_read(at(2, i), d, oe);
      check(d == pat(i), "R4 R3 R2 page byte", d, pat(i));
    end
    do_read(at(2, 31), d, oe);
    do_read(at(2, 31), d2, oe);
    check(d == d2 && d == pat(31), "R9 R10 true data steady", d2, pat(31));
  endtask

  task automatic t_partial();
    logic [7:0] d; logic oe; int n;
    do_write(at(2, 3), 8'h81);
    do_write(at(2, 17), 8'h18);
    while (rdy) @(negedge clk);
    n = 0;
    while (!rdy && n < 4 * PROG_CYC) begin n++; @(negedge clk); end
    check(n == PROG_CYC, "R7 busy length", n, PROG_CYC);
    do_read(at(2, 3), d, oe);
    check(d == 8'h81, "R4 partial byte 3", d, 8'h81);
    do_read(at(2, 17), d, oe);
    check(d == 8'h18, "R4 partial byte 17", d, 8'h18);
    do_read(at(2, 4), d, oe);
    check(d == pat(4), "R4 unloaded byte kept", d, pat(4));
  endtask

  task automatic t_foreign();
    logic [7:0] d; logic oe;
    do_write(at(5, 0), 8'h5A);
    wait_ready(); repeat (LOAD_CYC + 4) @(negedge clk); wait_ready();
    do_write(at(2, 1), 8'hC3);
    do_write(at(2, 2), 8'h3C);
    do_write(at(5, 0), 8'hEE);
    repeat (LOAD_CYC + 2) @(negedge clk);
    do_read(at(2, 1), d, oe);
    check(d[7] == 1'b1, "R11 poll uses last accepted byte", d[7], 1);
    wait_ready();
    do_read(at(5, 0), d, oe);
    check(d == 8'h5A, "R6 foreign page ignored", d, 8'h5A);
    do_read(at(2, 1), d, oe);
    check(d == 8'hC3, "R6 own page byte 1", d, 8'hC3);
    do_read(at(2, 2), d, oe);
    check(d == 8'h3C, "R6 own page byte 2", d, 8'h3C);
  endtask

  task automatic t_busy_write();
    logic [7:0] d; logic oe;
    do_write(at(2, 5), 8'h44);
    while (rdy) @(negedge clk);
    do_write(at(2, 6), 8'h99);
    wait_ready();
    repeat (LOAD_CYC + 10) @(negedge clk);
    check(rdy == 1'b1, "R8 no new cycle from busy write", rdy, 1);
    do_read(at(2, 6), d, oe);
    check(d == pat(6), "R8 busy write ignored", d, pat(6));
    do_read(at(2, 5), d, oe);
    check(d == 8'h44, "R4 single byte commit", d, 8'h44);
  endtask

  task automatic t_powergood();
    logic [7:0] d; logic oe;
    @(negedge clk); pwr_ok_n = 0;
    do_write(at(2, 7), 8'h00);
    check(rdy == 1'b1 && dq_oe == 1'b0, "R1 outputs held", rdy, 1);
    @(negedge clk); pwr_ok_n = 1;
    repeat (LOAD_CYC + 10) @(negedge clk);
    check(rdy == 1'b1, "R1 no programming from blocked write", rdy, 1);
    do_read(at(2, 7), d, oe);
    check(d == pat(7), "R1 blocked write left array", d, pat(7));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_page();
        t_partial();
        t_foreign();
        t_busy_write();
        t_powergood();
        done = 1;
      end
      begin
        repeat (150000) @(negedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=timeout expected=done");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule